// File: doc/BRIEF.md
# Power-Up Bad-Block Marker Scanner

After power-up this block visits every erase block of a NAND array once, in ascending order. For each block it requests the first page and receives the start of that page's spare area as a stream of beats. It then records one good/bad bit per block in an internal bitmap. The device's command and timing layer sits outside the block and is modelled as a request handshake followed by a response beat stream. Error correction is also outside the block.

An erase block is bad when its factory mark is not all ones. A byte-wide device carries the mark in spare-area bytes 0 and 5. A word-wide device carries it in the first spare-area word. The scanner keeps a saturating count of bad blocks and raises a done flag once the final block has been classified. A lookup port lets the allocator check any block index at any time, so no block found bad is handed out.

Top module: `bbs_scanner`

## Requirements
- R1: After reset `scan_done`, `req_valid`, `bad_count` and `lkp_bad` are all 0.
- R2: A `start` pulse while idle or done launches a scan. The scan issues exactly one request per block, for block 0 up to block NUM_BLOCKS-1 in that order. Each request addresses page 0 of its block: `req_row` = block × PAGES_PER_BLOCK.
- R3: In byte mode (`bus_wide`=0 at start), each request uses `req_col` = PAGE_DATA_BYTES and `req_len` = 6. The block is bad when bits [7:0] of beat 0 or of beat 5 differ from 0xFF. Beats 1 to 4 and bits [15:8] of every beat have no effect.
- R4: In word mode (`bus_wide`=1 at start), each request uses `req_col` = PAGE_DATA_BYTES/2 (word column) and `req_len` = 1. The block is bad when the 16-bit beat differs from 0xFFFF.
- R5: `bus_wide` is sampled only on the cycle a scan starts. Changing it during a scan has no effect on that scan.
- R6: `lkp_bad` is 1 for a block this scan has classified as bad. It is 0 for a good block and for any block this scan has not yet classified, including blocks marked bad by an earlier scan.
- R7: `scan_done` rises after the last block is classified and stays high until the next start. While it is high, `req_valid` is 0.
- R8: `bad_count` clears at start, increases by one per bad block, and saturates at 2^CNT_W-1.
- R9: A `start` pulse during a scan is ignored.
- R10: A pending request holds `req_valid`, `req_row`, `req_col` and `req_len` steady until `req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle scan launch |
| bus_wide | input | 1 | 1 = word-wide device, 0 = byte-wide |
| req_valid | output | 1 | Page-read request pending |
| req_ready | input | 1 | Request accepted this cycle |
| req_row | output | ROW_W | Row (block × pages + page) to read |
| req_col | output | COL_W | Starting column of the marker |
| req_len | output | 3 | Number of beats wanted |
| rsp_valid | input | 1 | Response beat present |
| rsp_data | input | 16 | Response beat, byte in [7:0] in byte mode |
| lkp_idx | input | BLK_W | Block index to look up |
| lkp_bad | output | 1 | Looked-up block is bad |
| bad_count | output | CNT_W | Saturating bad-block count |
| scan_done | output | 1 | All blocks classified |

## Verification
The bench places non-0xFF bytes in spare positions 1 to 4 and in the upper lane of byte-mode beats. A scanner that compared the wrong offsets would then mark good blocks bad. Word-mode markers with only the upper or only the lower byte cleared catch a comparison that checks just one lane.

Width is toggled mid-scan and `start` is re-pulsed mid-scan. A scanner that resampled the width would change its request length, and one that restarted would re-request block 0; either way the ordered request scoreboard reports a mismatch. A stale bitmap bit from an earlier scan is probed before it is rescanned, which catches a lookup that is not gated by scan progress. A scan with more bad blocks than the counter range shows whether the count wraps instead of saturating.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } scan_st_e;

    // byte mode: beats 0..5 of the spare area, marker in beats 0 and 5
    localparam logic [2:0]  BYTE_BEATS = 3'd6;
    localparam logic [2:0]  BYTE_LAST  = 3'd5;
    localparam logic [2:0]  WORD_BEATS = 3'd1;
    localparam logic [7:0]  ONES8      = 8'hFF;
    localparam logic [15:0] ONES16     = 16'hFFFF;
endpackage

// File: rtl/bbs_marker_eval.sv
module bbs_marker_eval
    import bbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wide,
    input  logic        beat_valid,
    input  logic [15:0] beat_data,
    output logic        verdict_valid,
    output logic        verdict_bad
);
    typedef struct packed {
        logic [2:0] idx;
        logic       acc;
    } mev_t;

    mev_t s_d, s_q;
    logic beat_last;
    logic beat_hit;

    always_comb begin
        beat_last = wide ? 1'b1 : (s_q.idx == BYTE_LAST);
        if (wide)
            beat_hit = (beat_data != ONES16);
        else
            beat_hit = ((s_q.idx == 3'd0) || (s_q.idx == BYTE_LAST))
                       && (beat_data[7:0] != ONES8);
        verdict_valid = beat_valid && beat_last;
        verdict_bad   = s_q.acc || beat_hit;

        s_d = s_q;
        if (clear) begin
            s_d.idx = '0;
            s_d.acc = 1'b0;
        end else if (beat_valid) begin
            if (beat_last) begin
                s_d.idx = '0;
                s_d.acc = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 3'd1;
                s_d.acc = s_q.acc || beat_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int FILL_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_idx,
    input  logic              wr_bad,
    input  logic [FILL_W-1:0] fill,
    input  logic [BLK_W-1:0]  rd_idx,
    output logic              rd_bad
);
    logic [NUM_BLOCKS-1:0] map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (clr)
            map_d = '0;
        else if (wr_en)
            map_d[wr_idx] = wr_bad;
        // only indices already classified in this scan can read as bad
        if (FILL_W'(rd_idx) < fill)
            rd_bad = map_q[rd_idx];
        else
            rd_bad = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end
endmodule

// File: rtl/bbs_sat_counter.sv
module bbs_sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != {W{1'b1}}))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bbs_scanner.sv
module bbs_scanner
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_DATA_BYTES = 2048,
    parameter int SPARE_BYTES     = 64,
    parameter int CNT_W           = 12,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int ROW_W  = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
    localparam int COL_W  = $clog2(PAGE_DATA_BYTES + SPARE_BYTES),
    localparam int FILL_W = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bus_wide,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ROW_W-1:0] req_row,
    output logic [COL_W-1:0] req_col,
    output logic [2:0]       req_len,
    input  logic             rsp_valid,
    input  logic [15:0]      rsp_data,
    input  logic [BLK_W-1:0] lkp_idx,
    output logic             lkp_bad,
    output logic [CNT_W-1:0] bad_count,
    output logic             scan_done
);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [COL_W-1:0] COL_BYTE  = COL_W'(PAGE_DATA_BYTES);
    localparam logic [COL_W-1:0] COL_WORD  = COL_W'(PAGE_DATA_BYTES / 2);

    typedef struct packed {
        scan_st_e          st;
        logic [BLK_W-1:0]  ptr;
        logic [FILL_W-1:0] fill;
        logic              wide;
    } ctl_t;

    ctl_t c_d, c_q;

    logic launch;
    logic req_take;
    logic beat_ok;
    logic v_valid, v_bad;
    logic classify;

    bbs_marker_eval u_eval (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (req_take),
        .wide          (c_q.wide),
        .beat_valid    (beat_ok),
        .beat_data     (rsp_data),
        .verdict_valid (v_valid),
        .verdict_bad   (v_bad)
    );

    bbs_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (launch),
        .wr_en  (classify),
        .wr_idx (c_q.ptr),
        .wr_bad (v_bad),
        .fill   (c_q.fill),
        .rd_idx (lkp_idx),
        .rd_bad (lkp_bad)
    );

    bbs_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .inc   (classify && v_bad),
        .cnt   (bad_count)
    );

    always_comb begin
        launch    = start && ((c_q.st == ST_IDLE) || (c_q.st == ST_DONE));
        req_valid = (c_q.st == ST_REQ);
        req_take  = req_valid && req_ready;
        beat_ok   = (c_q.st == ST_RSP) && rsp_valid;
        classify  = beat_ok && v_valid;
        scan_done = (c_q.st == ST_DONE);
        req_row   = ROW_W'(c_q.ptr) * ROW_W'(PAGES_PER_BLOCK);
        req_col   = c_q.wide ? COL_WORD : COL_BYTE;
        req_len   = c_q.wide ? WORD_BEATS : BYTE_BEATS;

        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (launch) begin
                    c_d.st   = ST_REQ;
                    c_d.ptr  = '0;
                    c_d.fill = '0;
                    c_d.wide = bus_wide;
                end
            end
            ST_REQ: begin
                if (req_ready) c_d.st = ST_RSP;
            end
            ST_RSP: begin
                if (classify) begin
                    c_d.fill = c_q.fill + 1'b1;
                    if (c_q.ptr == LAST_BLK) begin
                        c_d.st = ST_DONE;
                    end else begin
                        c_d.ptr = c_q.ptr + 1'b1;
                        c_d.st  = ST_REQ;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, ptr: '0, fill: '0, wide: 1'b0};
        else        c_q <= c_d;
    end
endmodule

// File: rtl/bbs_scanner_chk.sv
module bbs_scanner_chk #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_DATA_BYTES = 2048,
    parameter int ROW_W           = 17,
    parameter int COL_W           = 12,
    parameter int CNT_W           = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [ROW_W-1:0] req_row,
    input logic [COL_W-1:0] req_col,
    input logic [2:0]       req_len,
    input logic [CNT_W-1:0] bad_count,
    input logic             scan_done
);
    // R2
    page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_row % ROW_W'(PAGES_PER_BLOCK)) == '0));

    // R3
    mode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_len == 3'd6 && req_col == COL_W'(PAGE_DATA_BYTES)) ||
                       (req_len == 3'd1 && req_col == COL_W'(PAGE_DATA_BYTES / 2))));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !req_valid);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_count != $past(bad_count)) |->
            ((bad_count == $past(bad_count) + 1'b1) || (bad_count == '0)));

    // R8
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_count == {CNT_W{1'b1}}) |=> ((bad_count == {CNT_W{1'b1}}) || (bad_count == '0)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_row) && $stable(req_col) && $stable(req_len)));
endmodule

bind bbs_scanner bbs_scanner_chk #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_DATA_BYTES (PAGE_DATA_BYTES),
    .ROW_W           (ROW_W),
    .COL_W           (COL_W),
    .CNT_W           (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_len   (req_len),
    .bad_count (bad_count),
    .scan_done (scan_done)
);

// File: tb/bbs_scanner_tb.sv
module bbs_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 16;
    localparam int PG    = 4;
    localparam int DATA  = 2048;
    localparam int CW    = 3;
    localparam int BLK_W = $clog2(NB);
    localparam int ROW_W = $clog2(NB * PG);
    localparam int COL_W = $clog2(DATA + 64);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_wide = 1'b0;
    logic req_valid;
    logic req_ready = 1'b0;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [2:0] req_len;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;
    logic [BLK_W-1:0] lkp_idx = '0;
    logic lkp_bad;
    logic [CW-1:0] bad_count;
    logic scan_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bbs_scanner #(
        .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PG), .PAGE_DATA_BYTES(DATA),
        .SPARE_BYTES(64), .CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_wide(bus_wide),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .lkp_idx(lkp_idx), .lkp_bad(lkp_bad),
        .bad_count(bad_count), .scan_done(scan_done)
    );

    typedef struct { int row; int col; int len; } exp_t;
    exp_t exp_q[$];

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0]  m8  [NB][6];
    logic [15:0] m16 [NB];
    bit wide_model = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic bit exp_bad(input int b, input bit wide);
        if (wide) return m16[b] != 16'hFFFF;
        return (m8[b][0] != 8'hFF) || (m8[b][5] != 8'hFF);
    endfunction

    task automatic clear_marks();
        for (int b = 0; b < NB; b++) begin
            m16[b] = 16'hFFFF;
            for (int i = 0; i < 6; i++) m8[b][i] = 8'hFF;
        end
    endtask

    // monitor + response model: pops expected request, serves beats
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                int blk;
                int n;
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 extra request", int'(req_row), -1);
                    e = '{row: int'(req_row), col: int'(req_col), len: int'(req_len)};
                end else begin
                    e = exp_q.pop_front();
                    chk(int'(req_row) == e.row, "R2 row", int'(req_row), e.row);
                    chk(int'(req_col) == e.col, "R3/R4 col", int'(req_col), e.col);
                    chk(int'(req_len) == e.len, "R3/R4/R5 len", int'(req_len), e.len);
                end
                blk = int'(req_row) / PG;
                n   = int'(req_len);
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                for (int i = 0; i < n; i++) begin
                    rsp_valid = 1'b1;
                    if (wide_model) rsp_data = m16[blk % NB];
                    else            rsp_data = {8'h00, m8[blk % NB][i % 6]};
                    @(negedge clk);
                    if (i == 2) begin
                        rsp_valid = 1'b0;
                        @(negedge clk);
                    end
                end
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic lookup(input int b, output bit v);
        lkp_idx = BLK_W'(b);
        #1;
        v = lkp_bad;
    endtask

    task automatic run_scan(input bit wide, input bit flip, input bit restart, input string tag);
        int exp_cnt = 0;
        bit v;
        int waited;
        wide_model = wide;
        bus_wide   = wide;
        for (int b = 0; b < NB; b++) begin
            exp_q.push_back('{row: b * PG, col: wide ? DATA / 2 : DATA, len: wide ? 1 : 6});
            if (exp_bad(b, wide)) exp_cnt++;
        end
        if (exp_cnt > (1 << CW) - 1) exp_cnt = (1 << CW) - 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R6: final block not yet classified must read good
        lookup(NB - 1, v);
        chk(v == 1'b0, {"R6 unscanned ", tag}, v, 0);
        if (flip) bus_wide = ~wide;          // R5
        if (restart) begin                   // R9
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!scan_done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk(scan_done == 1'b1, {"R7 done ", tag}, scan_done, 1);
        chk(exp_q.size() == 0, {"R2/R9 requests left ", tag}, exp_q.size(), 0);
        chk(int'(bad_count) == exp_cnt, {"R8 count ", tag}, int'(bad_count), exp_cnt);
        for (int b = 0; b < NB; b++) begin
            lookup(b, v);
            chk(v == exp_bad(b, wide), {"R3/R4/R6 lookup ", tag}, v, exp_bad(b, wide));
        end
        repeat (5) @(negedge clk);
        chk(scan_done == 1'b1 && req_valid == 1'b0, {"R7 hold ", tag}, req_valid, 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        n_vec++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit v;
        clear_marks();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scan_done == 1'b0, "R1 done", scan_done, 0);
        chk(req_valid == 1'b0, "R1 req", req_valid, 0);
        chk(bad_count == '0, "R1 count", int'(bad_count), 0);
        lookup(0, v);
        chk(v == 1'b0, "R1 lookup", v, 0);

        // byte mode: offsets 0 and 5 count, 1..4 and upper lane do not (R3)
        clear_marks();
        m8[1][0]  = 8'h00;
        m8[4][5]  = 8'hFE;
        for (int i = 1; i < 5; i++) m8[7][i] = 8'h00;
        m8[15][0] = 8'h7F;
        m16[2]    = 16'h0000;
        run_scan(1'b0, 1'b0, 1'b0, "byte");

        // word mode, width flipped and start repulsed mid-scan (R4 R5 R9 R6)
        clear_marks();
        m16[0]  = 16'h0000;
        m16[5]  = 16'h7FFF;
        m16[9]  = 16'h00FF;
        m16[12] = 16'hFF00;
        m16[15] = 16'hFFFE;
        m8[3][0] = 8'h00;
        run_scan(1'b1, 1'b1, 1'b1, "word");

        // byte mode with more bad blocks than the counter holds (R8)
        clear_marks();
        for (int b = 0; b < 12; b++) begin
            if (b % 2 == 0) m8[b][0] = 8'h00;
            else            m8[b][5] = 8'h3C;
        end
        run_scan(1'b0, 1'b1, 1'b0, "sat");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule